// File: doc/BRIEF.md
# Speculative Register Tag Table

This block is the issue-side register status table of an out-of-order core with reservation stations and a reorder buffer. Each architectural register holds one of two things. It is either a usable value, or the tag of the station whose result it is waiting for. Each issued instruction reads two source registers through combinational lookup ports. If the instruction has a destination, that register is renamed to the tag of the receiving station.

The table snoops the common result bus. A broadcast fills a register only while that register still waits on the broadcast tag. A stale producer therefore cannot overwrite a newer rename.

Beside the speculative copy, the table keeps a commit-side copy of every register, written in program order by the reorder buffer. When a branch turns out to be mispredicted, the flush input copies the whole commit-side state into the issue side in one cycle, and every pending tag is dropped.

Top module: `spec_tag_table`

## Requirements
- R1: After reset every issue-side register reads ready with value 0, and every commit-side register holds 0.
- R2: Each of the two lookup ports returns, in the same cycle, the ready flag, value and tag of the register its index selects; the tag is meaningful only when ready is 0.
- R3: An issue with `iss_valid`=1 and `iss_has_dst`=1 makes register `iss_dst` read not ready with tag `iss_tag` from the next cycle.
- R4: A later rename of the same register replaces its tag; a broadcast of the replaced older tag leaves the register waiting on the newer tag.
- R5: A bus broadcast whose tag equals the tag of a waiting register makes that register ready with the broadcast value on the next cycle.
- R6: A lookup of a register renamed in the same cycle returns the state from before the rename.
- R7: When a matching broadcast and a rename hit the same register in one cycle, the rename wins and the register waits on the new tag.
- R8: An issue with `iss_has_dst`=0 changes no register, whatever `iss_dst` and `iss_tag` carry.
- R9: A commit writes `cmt_value` into the commit-side copy of `cmt_reg` and does not change the issue side.
- R10: A flush makes every issue-side register ready with its commit-side value on the next cycle. A commit in the same cycle is included, and a rename or broadcast in that cycle is overridden.
- R11: A broadcast never changes a register that is already ready, even when its stale tag field matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_has_dst | input | 1 | The issuing instruction writes a register |
| iss_dst | input | AW | Destination register index |
| iss_tag | input | TW | Station tag that will produce the destination |
| src_a | input | AW | Lookup index, port A |
| src_b | input | AW | Lookup index, port B |
| a_ready | output | 1 | Port A register holds a value |
| a_value | output | DW | Port A register value |
| a_tag | output | TW | Port A pending producer tag |
| b_ready | output | 1 | Port B register holds a value |
| b_value | output | DW | Port B register value |
| b_tag | output | TW | Port B pending producer tag |
| bus_valid | input | 1 | Result broadcast present |
| bus_tag | input | TW | Tag of the broadcasting station |
| bus_value | input | DW | Broadcast result |
| cmt_valid | input | 1 | Commit write this cycle |
| cmt_reg | input | AW | Committed register index |
| cmt_value | input | DW | Committed value |
| flush | input | 1 | Misprediction: reload issue side from commit side |

## Verification
The bench builds the table with four registers, 8-bit values and 2-bit tags. With four registers, one flush is followed by a check of every entry, so restoring the whole table is checked in full. With 2-bit tags, the same small set of tag values comes back in renames, stale broadcasts and rename-versus-broadcast collisions. The stale-tag and collision cases therefore use values that also occur as real matches.

// File: rtl/spec_tag_table.sv
`timescale 1ns/1ps
module spec_tag_table #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int TW   = 4,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic          iss_has_dst,
  input  logic [AW-1:0] iss_dst,
  input  logic [TW-1:0] iss_tag,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  output logic          a_ready,
  output logic [DW-1:0] a_value,
  output logic [TW-1:0] a_tag,
  output logic          b_ready,
  output logic [DW-1:0] b_value,
  output logic [TW-1:0] b_tag,
  input  logic          bus_valid,
  input  logic [TW-1:0] bus_tag,
  input  logic [DW-1:0] bus_value,
  input  logic          cmt_valid,
  input  logic [AW-1:0] cmt_reg,
  input  logic [DW-1:0] cmt_value,
  input  logic          flush
);

  logic [NREG-1:0]         rdy_v;
  logic [NREG-1:0][TW-1:0] tag_v;
  logic [NREG-1:0][DW-1:0] val_v;
  logic [NREG-1:0][DW-1:0] cval_v;

  wire rename = iss_valid & iss_has_dst;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          r;
    logic [TW-1:0] t;
    logic [DW-1:0] v;
    logic [DW-1:0] c;

    wire           cw    = cmt_valid && (cmt_reg == AW'(g));
    wire [DW-1:0]  cnext = cw ? cmt_value : c;
    wire           rn    = rename && (iss_dst == AW'(g));
    wire           hit   = bus_valid && !r && (t == bus_tag);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r <= 1'b1;
        t <= '0;
        v <= '0;
        c <= '0;
      end else begin
        c <= cnext;
        if (flush) begin
          r <= 1'b1;
          v <= cnext;
        end else if (rn) begin
          r <= 1'b0;
          t <= iss_tag;
        end else if (hit) begin
          r <= 1'b1;
          v <= bus_value;
        end
      end
    end

    assign rdy_v[g]  = r;
    assign tag_v[g]  = t;
    assign val_v[g]  = v;
    assign cval_v[g] = c;
  end

  assign a_ready = rdy_v[src_a];
  assign a_value = val_v[src_a];
  assign a_tag   = tag_v[src_a];
  assign b_ready = rdy_v[src_b];
  assign b_value = val_v[src_b];
  assign b_tag   = tag_v[src_b];

endmodule

module spec_tag_table_chk #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int TW   = 4,
  parameter int AW   = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    iss_valid,
  input logic                    iss_has_dst,
  input logic [AW-1:0]           iss_dst,
  input logic [TW-1:0]           iss_tag,
  input logic                    bus_valid,
  input logic                    cmt_valid,
  input logic [AW-1:0]           cmt_reg,
  input logic [DW-1:0]           cmt_value,
  input logic                    flush,
  input logic [NREG-1:0]         rdy_v,
  input logic [NREG-1:0][TW-1:0] tag_v,
  input logic [NREG-1:0][DW-1:0] val_v,
  input logic [NREG-1:0][DW-1:0] cval_v
);

  p_rename_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_has_dst && !flush) |=>
      (!rdy_v[$past(iss_dst)] && tag_v[$past(iss_dst)] == $past(iss_tag)));

  p_no_dst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_has_dst && !bus_valid && !flush) |=>
      ($stable(rdy_v) && $stable(tag_v) && $stable(val_v)));

  p_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |=> (cval_v[$past(cmt_reg)] == $past(cmt_value)));

  p_flush_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rdy_v == '1));

  p_flush_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !cmt_valid) |=> (val_v == $past(cval_v)));

  p_ready_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !(iss_valid && iss_has_dst)) |=>
      ((rdy_v & $past(rdy_v)) == $past(rdy_v)));

endmodule

bind spec_tag_table spec_tag_table_chk #(.NREG(NREG), .DW(DW), .TW(TW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_has_dst(iss_has_dst),
  .iss_dst(iss_dst), .iss_tag(iss_tag), .bus_valid(bus_valid),
  .cmt_valid(cmt_valid), .cmt_reg(cmt_reg), .cmt_value(cmt_value), .flush(flush),
  .rdy_v(rdy_v), .tag_v(tag_v), .val_v(val_v), .cval_v(cval_v)
);

// File: tb/sim_spec_tag_table.sv
`timescale 1ns/1ps
module sim_spec_tag_table;
  localparam int NREG = 4, DW = 8, TW = 2, AW = 2;

  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, iss_has_dst = 0;
  logic [AW-1:0] iss_dst = '0, src_a = '0, src_b = '0, cmt_reg = '0;
  logic [TW-1:0] iss_tag = '0, bus_tag = '0, a_tag, b_tag;
  logic a_ready, b_ready, bus_valid = 0, cmt_valid = 0, flush = 0;
  logic [DW-1:0] a_value, b_value, bus_value = '0, cmt_value = '0;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spec_tag_table #(.NREG(NREG), .DW(DW), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_has_dst(iss_has_dst),
    .iss_dst(iss_dst), .iss_tag(iss_tag), .src_a(src_a), .src_b(src_b),
    .a_ready(a_ready), .a_value(a_value), .a_tag(a_tag),
    .b_ready(b_ready), .b_value(b_value), .b_tag(b_tag),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
    .cmt_valid(cmt_valid), .cmt_reg(cmt_reg), .cmt_value(cmt_value), .flush(flush));

  task automatic cyc();
    @(posedge clk); #1;
    iss_valid = 0; iss_has_dst = 0; bus_valid = 0; cmt_valid = 0; flush = 0;
  endtask

  task automatic peek(input int r, input bit er, input int ev, input string req);
    src_a = AW'(r); #0.2;
    vectors++;
    if (a_ready !== er || (er ? (a_value !== DW'(ev)) : (a_tag !== TW'(ev)))) begin
      miscompares++;
      $display("FAIL %s reg%0d: ready=%0b value=%0d tag=%0d, expected ready=%0b %s=%0d",
               req, r, a_ready, a_value, a_tag, er, er ? "value" : "tag", ev);
    end
  endtask

  task automatic rename(input int d, input int t);
    iss_valid = 1; iss_has_dst = 1; iss_dst = AW'(d); iss_tag = TW'(t);
  endtask

  task automatic bcast(input int t, input int v);
    bus_valid = 1; bus_tag = TW'(t); bus_value = DW'(v);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NREG; i++) peek(i, 1, 0, "R1");
    src_b = 2'd3; #0.2; vectors++;
    if (b_ready !== 1'b1 || b_value !== 8'd0) begin
      miscompares++;
      $display("FAIL R2 port B: ready=%0b value=%0d, expected 1 0", b_ready, b_value);
    end
  endtask

  task automatic t_commit_flush();
    for (int i = 0; i < NREG; i++) begin
      cmt_valid = 1; cmt_reg = AW'(i); cmt_value = DW'(11 * (i + 1)); cyc();
    end
    for (int i = 0; i < NREG; i++) peek(i, 1, 0, "R9");
    flush = 1; cyc();
    for (int i = 0; i < NREG; i++) peek(i, 1, 11 * (i + 1), "R10");
  endtask

  task automatic t_rename();
    rename(1, 2);
    peek(1, 1, 22, "R6");
    src_b = 2'd1; #0.2; vectors++;
    if (b_ready !== 1'b1 || b_value !== 8'd22) begin
      miscompares++;
      $display("FAIL R2 port B same-cycle: ready=%0b value=%0d, expected 1 22", b_ready, b_value);
    end
    cyc();
    peek(1, 0, 2, "R3");
  endtask

  task automatic t_stale_and_fill();
    rename(1, 3); cyc();
    peek(1, 0, 3, "R4");
    bcast(2, 99); cyc();
    peek(1, 0, 3, "R4");
    bcast(3, 77); cyc();
    peek(1, 1, 77, "R5");
    bcast(0, 5); cyc();
    peek(0, 1, 11, "R11");
  endtask

  task automatic t_collision();
    rename(2, 1); cyc();
    bcast(1, 55); rename(2, 0); cyc();
    peek(2, 0, 0, "R7");
  endtask

  task automatic t_no_dst();
    iss_valid = 1; iss_has_dst = 0; iss_dst = 2'd3; iss_tag = 2'd2; cyc();
    peek(3, 1, 44, "R8");
  endtask

  task automatic t_flush_override();
    cmt_valid = 1; cmt_reg = 2'd2; cmt_value = 8'd66;
    rename(3, 1); bcast(0, 9); flush = 1; cyc();
    peek(0, 1, 11, "R10");
    peek(1, 1, 22, "R10");
    peek(2, 1, 66, "R10");
    peek(3, 1, 44, "R10");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_commit_flush();
    t_rename();
    t_stale_and_fill();
    t_collision();
    t_no_dst();
    t_flush_override();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule